// File: doc/BRIEF.md
# I2C Target Byte Memory Front End

This block lets an I2C controller read and write an internal byte-wide memory holding 8K locations. It runs on a fast system clock and treats the two bus wires as slow inputs. Both wires pass through synchronizers. The block then finds bus conditions and clock edges on the oversampled levels. It never drives SDA high. It only asserts an open-drain enable that pulls the line low.

A transaction starts with a device byte. Its seven address bits must be binary 1010 followed by the three board strap bits. If the direction bit is 0, two pointer bytes follow and load a 13-bit location, and any further bytes are written there. If the direction bit is 1, bytes are sent starting at the stored pointer. The pointer keeps its value between transactions, so a read may either reuse the old location or follow a short pointer-loading write cut off by a repeated START. A byte that carries the high-speed master code is tolerated and left unacknowledged.

The storage array implements only the low `STORE_AW` pointer bits, 10 by default. Upper pointer bits take part in the count and the wrap but alias onto the same cells.

Top module: `i2c_mem_target`

## Requirements
- R1: After reset the pointer is 0x0000, `sda_oe_o` is 0 and the target waits for a START. A read issued right after reset returns the byte at location 0.
- R2: START (SDA falls while SCL is high) and repeated START restart byte framing at the device byte, even in the middle of a byte. STOP (SDA rises while SCL is high) releases SDA. A byte cut short by a repeated START is never stored.
- R3: A device byte whose bits 7..1 equal {1010, dev_sel_i} is acknowledged: `sda_oe_o` is high through the ninth SCL pulse and first rises only while SCL is low. Any other device byte gets no acknowledge, and every later byte is ignored (no acknowledge, no store, no pointer change) until the next START or STOP.
- R4: After a device byte with bit 0 = 0, the target acknowledges two pointer bytes, high byte first. Bits 7..5 of the high byte are ignored and bits 4..0 form pointer bits 12..8.
- R5: Bytes after the two pointer bytes are acknowledged and stored at the pointer, and the pointer then advances by one for each byte.
- R6: After a device byte with bit 0 = 1, the target sends the byte at the pointer most significant bit first, with SDA changing only while SCL is low. The pointer advances by one for each byte sent. A controller acknowledge (SDA low in the ninth pulse) requests another byte. A non-acknowledge releases SDA and ends the read.
- R7: The pointer wraps from 0x1FFF to 0x0000 on both writes and reads.
- R8: The pointer keeps its value across STOP and across ignored traffic. A read with no pointer phase continues from where the last transfer left it.
- R9: A byte of the form 00001xxx right after START gets no acknowledge. The repeated START that follows begins a normal addressed transaction.
- R10: Storage cells are selected by pointer bits STORE_AW-1..0 only (default 10 bits), so locations 1024 apart share a cell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| dev_sel_i | input | 3 | Strap bits forming the low part of the device address |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |

## Verification
The bench writes across the 0x1FFF boundary and reads back across it. A design with a missing wrap, or a pointer width off by one, would return a byte from the wrong cell. A device byte with the wrong strap bits is followed by a would-be write and then a plain read. A target that re-synchronised on a later byte would acknowledge or store data, and one that moved the pointer would return the wrong byte. It also sends the high-speed code before an addressed write and breaks a data byte with a repeated START. A target that acknowledged the code, or stored a partial byte, is caught by the acknowledge checks or by the read-back. A reset between a write and a plain read checks that the pointer returns to zero while the array contents survive.

// File: rtl/i2c_mem_pkg.sv
// Shared types for the I2C target byte memory.
// Assumes: states and phases are only decoded inside this block.
package i2c_mem_pkg;

    // Byte-level engine states
    typedef enum logic [2:0] {
        ST_IDLE,      // ignoring the bus until START/STOP
        ST_RX,        // shifting in a byte on SCL rising edges
        ST_ACK_WAIT,  // byte accepted, waiting for SCL low to drive ACK
        ST_ACK_DRIVE, // holding ACK for the ninth clock
        ST_TX,        // shifting out a byte on SCL falling edges
        ST_TX_ACK,    // SDA released, sampling the controller response
        ST_TX_NEXT    // controller acknowledged, load next byte on SCL low
    } eng_state_t;

    // Which byte of a write-type transfer is being received
    typedef enum logic [1:0] {
        PH_DEV,
        PH_AHI,
        PH_ALO,
        PH_DATA
    } phase_t;

    localparam logic [3:0] DEV_TYPE = 4'b1010;

endpackage

// File: rtl/i2c_line_sync.sv
// Synchronizes SCL and SDA into the system clock domain and finds
// SCL edges and START/STOP conditions on the synchronized levels.
// Assumes: the system clock samples each SCL phase several times.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic scl_q;
    logic sda_q;

    // Metastability chain plus one history flop per line; idle bus is high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_lvl   = scl_pipe[STAGES-1];
    assign sda_lvl   = sda_pipe[STAGES-1];
    assign scl_rise  = scl_lvl & ~scl_q;
    assign scl_fall  = ~scl_lvl & scl_q;
    assign start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;

endmodule

// File: rtl/i2c_byte_engine.sv
// Byte-level engine: device byte match, two pointer bytes, writes and
// sequential reads, ACK generation and controller ACK sampling.
// Assumes: inputs come from i2c_line_sync; rd_data is the registered
// content of the cell at ptr_o, valid one cycle after ptr_o changes.
module i2c_byte_engine
    import i2c_mem_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [2:0]        dev_sel,
    input  logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] ptr_o,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [7:0]        mem_wdata,
    output logic              sda_oe
);
    localparam int HI_W = ADDR_W - 8;
    localparam logic [ADDR_W-1:0] PTR_ONE = 1;

    eng_state_t  state;
    phase_t      phase;
    logic [2:0]  bit_cnt;
    logic [6:0]  rx_sh;
    logic [6:0]  tx_sh;
    logic        rd_mode;
    logic [7:0]  rx_byte;
    logic        dev_hit;

    // Byte being completed on this SCL rise
    assign rx_byte = {rx_sh, sda_lvl};
    assign dev_hit = (rx_byte[7:1] == {DEV_TYPE, dev_sel});

    // Main engine: bus conditions first, then per-state bit handling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            phase     <= PH_DEV;
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            rd_mode   <= 1'b0;
            ptr_o     <= '0;
            mem_we    <= 1'b0;
            mem_waddr <= '0;
            mem_wdata <= '0;
            sda_oe    <= 1'b0;
        end else begin
            mem_we <= 1'b0;
            if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (start_det) begin
                state   <= ST_RX;
                phase   <= PH_DEV;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else begin
                case (state)
                    ST_RX: if (scl_rise) begin
                        rx_sh   <= rx_byte[6:0];
                        bit_cnt <= bit_cnt + 3'd1;
                        if (bit_cnt == 3'd7) begin
                            state <= ST_ACK_WAIT;
                            case (phase)
                                PH_DEV: begin
                                    if (dev_hit) begin
                                        rd_mode <= rx_byte[0];
                                        phase   <= PH_AHI;
                                    end else begin
                                        state <= ST_IDLE;
                                    end
                                end
                                PH_AHI: begin
                                    ptr_o <= {rx_byte[HI_W-1:0], ptr_o[7:0]};
                                    phase <= PH_ALO;
                                end
                                PH_ALO: begin
                                    ptr_o[7:0] <= rx_byte;
                                    phase      <= PH_DATA;
                                end
                                default: begin
                                    mem_we    <= 1'b1;
                                    mem_waddr <= ptr_o;
                                    mem_wdata <= rx_byte;
                                    ptr_o     <= ptr_o + PTR_ONE;
                                end
                            endcase
                        end
                    end
                    ST_ACK_WAIT: if (scl_fall) begin
                        sda_oe <= 1'b1;
                        state  <= ST_ACK_DRIVE;
                    end
                    ST_ACK_DRIVE: if (scl_fall) begin
                        bit_cnt <= '0;
                        if (rd_mode) begin
                            sda_oe <= ~rd_data[7];
                            tx_sh  <= rd_data[6:0];
                            ptr_o  <= ptr_o + PTR_ONE;
                            state  <= ST_TX;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_RX;
                        end
                    end
                    ST_TX: if (scl_fall) begin
                        if (bit_cnt == 3'd7) begin
                            sda_oe <= 1'b0;
                            state  <= ST_TX_ACK;
                        end else begin
                            sda_oe  <= ~tx_sh[6];
                            tx_sh   <= {tx_sh[5:0], 1'b0};
                            bit_cnt <= bit_cnt + 3'd1;
                        end
                    end
                    ST_TX_ACK: if (scl_rise) begin
                        state <= sda_lvl ? ST_IDLE : ST_TX_NEXT;
                    end
                    ST_TX_NEXT: if (scl_fall) begin
                        bit_cnt <= '0;
                        sda_oe  <= ~rd_data[7];
                        tx_sh   <= rd_data[6:0];
                        ptr_o   <= ptr_o + PTR_ONE;
                        state   <= ST_TX;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R1: reset leaves pointer at zero, SDA released, engine idle
    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (ptr_o == '0 && !sda_oe && state == ST_IDLE));

    // R2: a STOP always releases the line
    a_r2_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R3: the line is only pulled while the engine is engaged
    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);

    // R3: the pull-down only begins while SCL is low
    a_r3_pull_on_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_lvl);

    // R6: the driven level never moves while SCL stays high
    a_r6_stable_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl && $past(scl_lvl) && !$past(start_det) && !$past(stop_det))
            |-> $stable(sda_oe));

    // R7: a store at the top location leaves the pointer at zero
    a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_waddr == '1) |-> (ptr_o == '0));

endmodule

// File: rtl/byte_store.sv
// Synchronous byte array: one write port, one registered read port.
// Assumes: no reset of contents; read data lags the address by a cycle.
module byte_store #(
    parameter int AW     = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] cells [DEPTH];

    // Write on request and register the addressed cell every cycle
    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
        rdata <= cells[raddr];
    end

endmodule

// File: rtl/i2c_mem_target.sv
// Top level: I2C target front end for an internal byte memory.
// Assumes: SCL and SDA are external open-drain lines; sda_oe_o = 1
// pulls SDA low. STORE_AW <= ADDR_W; upper pointer bits alias.
module i2c_mem_target #(
    parameter int ADDR_W   = 13,
    parameter int STORE_AW = 10,
    parameter int SYNC_STG = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] dev_sel_i,
    output logic       sda_oe_o
);
    logic              scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic [ADDR_W-1:0] ptr;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [7:0]        mem_wdata;
    logic [7:0]        rd_data;

    i2c_line_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    i2c_byte_engine #(.ADDR_W(ADDR_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
        .stop_det(stop_det), .dev_sel(dev_sel_i), .rd_data(rd_data),
        .ptr_o(ptr), .mem_we(mem_we), .mem_waddr(mem_waddr),
        .mem_wdata(mem_wdata), .sda_oe(sda_oe_o)
    );

    // Storage index selection: aliased when the array is shallower
    generate
        if (STORE_AW < ADDR_W) begin : g_alias
            logic unused_ptr_hi;
            assign unused_ptr_hi = ^{ptr[ADDR_W-1:STORE_AW], mem_waddr[ADDR_W-1:STORE_AW]};
        end
    endgenerate

    byte_store #(.AW(STORE_AW), .DATA_W(8)) u_store (
        .clk(clk), .we(mem_we), .waddr(mem_waddr[STORE_AW-1:0]),
        .wdata(mem_wdata), .raddr(ptr[STORE_AW-1:0]), .rdata(rd_data)
    );

endmodule

// File: tb/i2c_mem_target_tb.sv
// Scoreboard bench: driver tasks push expected read bytes into a queue,
// a monitor pops and compares each byte the target sends.
module i2c_mem_target_tb;
    localparam int Q = 4;              // quarter SCL bit time in clocks
    localparam int MASK = 1023;        // R10 storage index mask
    localparam logic [7:0] DEV_W = 8'hAA; // 1010_101_0
    localparam logic [7:0] DEV_R = 8'hAB; // 1010_101_1

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic [2:0] sel = 3'b101;
    logic sda_oe;
    logic sda_bus;
    assign sda_bus = sda_m & ~sda_oe;

    int total = 0;
    int bad = 0;
    logic [7:0] model [MASK+1];
    int mptr = 0;
    logic [7:0] exp_q [$];
    string tag_q [$];
    logic [7:0] rd_val;
    event rd_evt;

    always #5 clk = ~clk;

    i2c_mem_target u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
        .dev_sel_i(sel), .sda_oe_o(sda_oe)
    );

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            wq(); sda_m = b[i]; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string tag);
        logic got;
        send_bits(b, 8);
        wq(); sda_m = 1'b1; wq(); scl = 1'b1; wq();
        got = ~sda_bus;
        check(got == exp_ack, tag, got, exp_ack);
        wq(); scl = 1'b0;
    endtask

    task automatic write_data(input logic [7:0] b, input string tag);
        send_byte(b, 1'b1, tag);
        model[mptr & MASK] = b;
        mptr = (mptr + 1) & 16'h1FFF;
    endtask

    // Driver side of the scoreboard: queue the expected byte, then read
    task automatic read_byte(input bit mack, input string tag);
        logic [7:0] v;
        exp_q.push_back(model[mptr & MASK]);
        tag_q.push_back(tag);
        mptr = (mptr + 1) & 16'h1FFF;
        sda_m = 1'b1;
        v = '0;
        for (int i = 0; i < 8; i++) begin
            wq(); wq(); scl = 1'b1; wq(); v = {v[6:0], sda_bus}; wq(); scl = 1'b0;
        end
        wq(); sda_m = ~mack; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0;
        sda_m = 1'b1;
        rd_val = v;
        ->rd_evt;
    endtask

    // Pointer-loading write; top three bits of the high byte are junk (R4)
    task automatic set_ptr(input int addr, input string tag);
        bus_start();
        send_byte(DEV_W, 1'b1, tag);
        send_byte({3'b101, 5'(addr >> 8)}, 1'b1, "R4 high pointer byte ack");
        send_byte(8'(addr), 1'b1, "R4 low pointer byte ack");
        mptr = addr & 16'h1FFF;
    endtask

    // Monitor side of the scoreboard
    initial begin
        forever begin
            @(rd_evt);
            if (exp_q.size() == 0) begin
                check(1'b0, "read with empty scoreboard", rd_val, 0);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rd_val == e, t, rd_val, e);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        wq();
        check(sda_oe == 1'b0, "R1 line released after reset", sda_oe, 0);

        // R4/R5: write three bytes starting at location 0
        set_ptr(0, "R3 matching device byte acked");
        write_data(8'h5A, "R5 data byte 0 ack");
        write_data(8'hA5, "R5 data byte 1 ack");
        write_data(8'h3C, "R5 data byte 2 ack");
        bus_stop();

        // R1: reset returns the pointer to 0 but keeps the array
        rst_n = 1'b0; repeat (3) @(negedge clk); rst_n = 1'b1; wq();
        mptr = 0;
        bus_start();
        send_byte(DEV_R, 1'b1, "R1 read device byte ack");
        read_byte(1'b0, "R1 first read after reset from 0");
        bus_stop();

        // R8/R6: plain read continues from stored pointer, sequential
        bus_start();
        send_byte(DEV_R, 1'b1, "R8 read device byte ack");
        read_byte(1'b1, "R8 continues at location 1");
        read_byte(1'b0, "R6 sequential byte at location 2");
        bus_stop();
        check(sda_oe == 1'b0, "R6 line released after NACK and STOP", sda_oe, 0);

        // R6: random read via repeated START
        set_ptr(1, "R6 random read pointer phase");
        bus_start();
        send_byte(DEV_R, 1'b1, "R6 read after repeated START");
        read_byte(1'b0, "R6 random read of location 1");
        bus_stop();

        // R7: write across the top of the pointer range
        set_ptr(16'h1FFE, "R7 pointer near top");
        write_data(8'h11, "R7 store at 0x1FFE");
        write_data(8'h22, "R7 store at 0x1FFF");
        write_data(8'h33, "R7 store after wrap");
        bus_stop();
        set_ptr(16'h1FFF, "R7 read pointer phase");
        bus_start();
        send_byte(DEV_R, 1'b1, "R7 read device byte");
        read_byte(1'b1, "R7 read 0x1FFF");
        read_byte(1'b0, "R7 read wraps to 0x0000");
        bus_stop();

        // R10: location 0x03FE aliases 0x1FFE
        set_ptr(16'h03FE, "R10 alias pointer phase");
        bus_start();
        send_byte(DEV_R, 1'b1, "R10 read device byte");
        read_byte(1'b0, "R10 aliased cell");
        bus_stop();

        // R3: wrong strap bits; following traffic ignored
        bus_start();
        send_byte(8'hA4, 1'b0, "R3 mismatched device byte not acked");
        send_byte(8'h00, 1'b0, "R3 ignored byte not acked");
        send_byte(8'h00, 1'b0, "R3 ignored byte not acked");
        send_byte(8'h77, 1'b0, "R3 ignored data not acked");
        bus_stop();
        bus_start();
        send_byte(DEV_R, 1'b1, "R8 read after ignored traffic");
        read_byte(1'b0, "R3 R8 pointer and cell untouched");
        bus_stop();

        // R9: high-speed code prefix, then addressed write
        bus_start();
        send_byte(8'h08, 1'b0, "R9 high-speed code not acked");
        set_ptr(16'h0010, "R9 addressed write after code");
        write_data(8'h99, "R9 data ack");
        bus_stop();
        set_ptr(16'h0010, "R9 read-back pointer");
        bus_start();
        send_byte(DEV_R, 1'b1, "R9 read device byte");
        read_byte(1'b0, "R9 stored byte");
        bus_stop();

        // R2: repeated START mid-byte aborts the byte without storing
        set_ptr(16'h0010, "R2 pointer phase");
        send_bits(8'h00, 3);
        bus_start();
        send_byte(DEV_R, 1'b1, "R2 device byte after mid-byte restart");
        read_byte(1'b0, "R2 partial byte not stored");
        bus_stop();
        check(sda_oe == 1'b0, "R2 line released after STOP", sda_oe, 0);

        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        summary();
    end

endmodule